// File: doc/BRIEF.md
# Playback Format Converter and Attenuator

This block sits between the packet side of a streaming audio sink and the digital-to-analog converter. It receives a byte stream in one of six sample formats, chosen by a format selector. The formats cover 16-bit or 8-bit samples, stereo or mono, and 8-bit data in two's complement or offset binary. A seventh setting carries no audio. Every format is turned into a stereo frame with 16-bit two's complement left and right samples, at the sample rate it arrived at. Frames wait in a buffer until the converter's sample tick takes them.

Playback begins only after a complete packet has been buffered and a start-of-frame pulse follows it. From then on, each sample tick takes one frame, scales each channel by its own attenuation and by a master mute, and places it on the output. When the buffer runs dry, the output falls back to bipolar zero, which is numeric 0. Control writes set the per-channel attenuation and the master mute. Each write is answered by an accept or a stall. A request aimed at a control that does not exist is stalled and has no effect.

Top module: `pb_playback_conv`

## Requirements
- R1: While reset is held and just after it is released, dac_left, dac_right, dac_strobe, ctl_done and ctl_stall are all 0.
- R2: With fmt_sel=1 (16-bit stereo), each frame is four bytes in the order left low, left high, right low, right high. The result is left={b1,b0} and right={b3,b2}.
- R3: With fmt_sel=2 (16-bit mono), each frame is two bytes, low then high. The 16-bit value goes to both channels.
- R4: With fmt_sel=3 (8-bit stereo, left byte first) or fmt_sel=4 (8-bit mono), a two's complement byte is placed in the upper byte of the 16-bit sample and the lower byte is 0. A mono byte goes to both channels.
- R5: With fmt_sel=5 (8-bit stereo) or fmt_sel=6 (8-bit mono), each offset-binary byte has its bit 7 inverted and is then widened as in R4.
- R6: With fmt_sel=0 or 7, bytes and byte_last are ignored. Nothing is buffered and playback does not start.
- R7: Playback starts on the first sof sampled after the edge that accepts the last byte of a packet, provided that packet produced at least one whole frame. Before that, each tick outputs 0. Once playing, each sample_tick takes the next frame in arrival order. dac_left, dac_right and dac_strobe=1 appear at the same clock edge that samples the tick. The outputs hold their value while dac_strobe is 0.
- R8: When a tick finds the buffer empty during playback, that tick and all later ticks output 0. A new packet and a new sof are then needed to start again.
- R9: Each channel has an attenuation of 0 to 64 dB in 1 dB steps. Larger values clamp to 64. The gain is g(0)=65536 and g(k+1)=floor((g(k)*58409+32768)/65536). The output is floor((s*g+32768)/65536). At 64 dB the output is exactly 0.
- R10: A volume write to ctl_chan=0 (master) or to ctl_chan=3 is stalled and changes no volume. Volume writes to ctl_chan=1 (left) and ctl_chan=2 (right) are accepted.
- R11: A mute write (ctl_mute_sel=1) is accepted only for ctl_chan=0, with ctl_value[0]=1 to mute and 0 to unmute. While muted, both outputs are 0. A mute write to any other channel is stalled and has no effect.
- R12: Each ctl_wr raises ctl_done for exactly the next cycle, with ctl_stall valid in that cycle. A new setting takes effect on ticks sampled from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Format of incoming bytes (0 none, 1..6 as in R2-R5, 7 none) |
| byte_valid | input | 1 | byte_data carries a stream byte this cycle |
| byte_data | input | 8 | Stream byte |
| byte_last | input | 1 | This byte ends its packet |
| sof | input | 1 | Start-of-frame pulse |
| ctl_wr | input | 1 | Control write strobe |
| ctl_chan | input | 2 | Target: 0 master, 1 left, 2 right, 3 none |
| ctl_mute_sel | input | 1 | 1 mute request, 0 volume request |
| ctl_value | input | 8 | Attenuation in dB, or mute flag in bit 0 |
| sample_tick | input | 1 | Converter requests the next sample |
| dac_left | output | 16 | Left output sample |
| dac_right | output | 16 | Right output sample |
| dac_strobe | output | 1 | Output samples were updated at this edge |
| ctl_done | output | 1 | Control response valid |
| ctl_stall | output | 1 | Control write was refused |

## Verification
A sample_tick driven before a clock edge produces its output and dac_strobe at that same edge. The bench drives every input on the falling edge and reads the results at the next falling edge, half a period after the register has loaded. A control write is answered one cycle later, so ctl_done and ctl_stall are read one falling edge after the write, and again one edge later to confirm the pulse ends. A buffered packet may be started by a sof driven in the cycle right after its last byte, and ticks issued before that sof are checked to be 0.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [2:0] {
    FMT_NONE   = 3'd0,
    FMT_S16_ST = 3'd1,
    FMT_S16_MO = 3'd2,
    FMT_S8_ST  = 3'd3,
    FMT_S8_MO  = 3'd4,
    FMT_U8_ST  = 3'd5,
    FMT_U8_MO  = 3'd6,
    FMT_NONE7  = 3'd7
  } pb_fmt_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PRIMED = 2'd1,
    SEQ_PLAY   = 2'd2
  } pb_seq_e;

  typedef struct packed {
    logic [15:0] l;
    logic [15:0] r;
  } pb_frame_t;

  // bytes needed to complete one frame; 0 marks a silent setting
  function automatic logic [2:0] pb_bytes_per_frame(input pb_fmt_e f);
    case (f)
      FMT_S16_ST: return 3'd4;
      FMT_S16_MO, FMT_S8_ST, FMT_U8_ST: return 3'd2;
      FMT_S8_MO, FMT_U8_MO: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // 8-bit sample to 16-bit: optional sign flip, then shift into the top byte
  function automatic logic [15:0] pb_widen8(input logic [7:0] b, input logic offs);
    return {b ^ {offs, 7'b0}, 8'h00};
  endfunction

  // one 1 dB step on a Q16 gain, rounded
  function automatic logic [33:0] pb_gain_step(input logic [33:0] g, input logic [16:0] step);
    logic [33:0] prod;
    prod = g * step;
    return (prod + 34'd32768) >> 16;
  endfunction

  // gain for k dB of attenuation, unity = 65536
  function automatic logic [16:0] pb_gain_at(input int k, input logic [16:0] step);
    logic [33:0] g;
    g = 34'd65536;
    for (int i = 0; i < k; i++) g = pb_gain_step(g, step);
    return g[16:0];
  endfunction

  // signed sample times unsigned Q16 gain, rounded half up
  function automatic logic [15:0] pb_scale(input logic [15:0] s, input logic [16:0] g);
    logic signed [34:0] p;
    p = $signed(s) * $signed({1'b0, g});
    p = p + 35'sd32768;
    return p[31:16];
  endfunction

endpackage

// File: rtl/pb_unpack.sv
module pb_unpack
  import pb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      fmt_sel,
  input  logic            byte_valid,
  input  logic [7:0]      byte_data,
  input  logic            byte_last,
  output logic            frame_valid,
  output pb_frame_t       frame,
  output logic            pkt_done
);

  pb_fmt_e    fmt;
  logic [1:0] cnt;
  logic [2:0] bpf;
  logic [2:0] pos;
  logic [7:0] hold [0:2];
  logic       frame_end;

  assign fmt       = pb_fmt_e'(fmt_sel);
  assign bpf       = pb_bytes_per_frame(fmt);
  assign pos       = {1'b0, cnt};
  assign frame_end = (bpf != 3'd0) && (pos == bpf - 3'd1);

  assign frame_valid = byte_valid && frame_end;
  assign pkt_done    = byte_valid && byte_last && (bpf != 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < 3; i++) hold[i] <= '0;
    end else if (byte_valid && (bpf != 3'd0)) begin
      if (frame_end || byte_last) begin
        cnt <= '0;
      end else if (cnt != 2'd3) begin
        hold[cnt] <= byte_data;
        cnt       <= cnt + 2'd1;
      end
    end
  end

  always_comb begin
    frame = '0;
    case (fmt)
      FMT_S16_ST: begin
        frame.l = {hold[1], hold[0]};
        frame.r = {byte_data, hold[2]};
      end
      FMT_S16_MO: begin
        frame.l = {byte_data, hold[0]};
        frame.r = {byte_data, hold[0]};
      end
      FMT_S8_ST: begin
        frame.l = pb_widen8(hold[0], 1'b0);
        frame.r = pb_widen8(byte_data, 1'b0);
      end
      FMT_S8_MO: begin
        frame.l = pb_widen8(byte_data, 1'b0);
        frame.r = pb_widen8(byte_data, 1'b0);
      end
      FMT_U8_ST: begin
        frame.l = pb_widen8(hold[0], 1'b1);
        frame.r = pb_widen8(byte_data, 1'b1);
      end
      FMT_U8_MO: begin
        frame.l = pb_widen8(byte_data, 1'b1);
        frame.r = pb_widen8(byte_data, 1'b1);
      end
      default: frame = '0;
    endcase
  end

endmodule

// File: rtl/pb_fifo.sv
module pb_fifo
  import pb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  pb_frame_t       din,
  input  logic            pop,
  output pb_frame_t       dout,
  output logic            empty,
  output logic [CW-1:0]   count
);

  pb_frame_t   mem [0:DEPTH-1];
  logic [AW-1:0] wptr, rptr;
  logic        wr_en, rd_en, full;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/pb_level.sv
module pb_level
  import pb_pkg::*;
#(
  parameter int          VOL_MAX_DB = 64,
  parameter logic [16:0] STEP_Q16   = 17'd58409,
  parameter int          CTL_W      = 8,
  localparam int         VW         = $clog2(VOL_MAX_DB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_chan,
  input  logic             ctl_mute_sel,
  input  logic [CTL_W-1:0] ctl_value,
  input  pb_frame_t        in_frame,
  output pb_frame_t        out_frame,
  output logic             mute_on,
  output logic             ctl_done,
  output logic             ctl_stall
);

  logic [16:0]   gain_rom [0:VOL_MAX_DB];
  logic [VW-1:0] vol_l, vol_r, vol_new;
  logic          accept;

  for (genvar k = 0; k <= VOL_MAX_DB; k++) begin : g_rom
    if (k >= VOL_MAX_DB) begin : g_silent
      assign gain_rom[k] = '0;
    end else begin : g_step
      assign gain_rom[k] = pb_gain_at(k, STEP_Q16);
    end
  end

  assign vol_new = (ctl_value >= CTL_W'(VOL_MAX_DB)) ? VW'(VOL_MAX_DB) : VW'(ctl_value);
  assign accept  = ctl_mute_sel ? (ctl_chan == 2'd0)
                                : (ctl_chan == 2'd1 || ctl_chan == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_l     <= '0;
      vol_r     <= '0;
      mute_on   <= 1'b0;
      ctl_done  <= 1'b0;
      ctl_stall <= 1'b0;
    end else begin
      ctl_done  <= ctl_wr;
      ctl_stall <= ctl_wr && !accept;
      if (ctl_wr && accept) begin
        if (ctl_mute_sel)           mute_on <= ctl_value[0];
        else if (ctl_chan == 2'd1)  vol_l   <= vol_new;
        else                        vol_r   <= vol_new;
      end
    end
  end

  always_comb begin
    out_frame.l = (mute_on || vol_l == VW'(VOL_MAX_DB)) ? '0 : pb_scale(in_frame.l, gain_rom[vol_l]);
    out_frame.r = (mute_on || vol_r == VW'(VOL_MAX_DB)) ? '0 : pb_scale(in_frame.r, gain_rom[vol_r]);
  end

endmodule

// File: rtl/pb_playback_conv.sv
module pb_playback_conv
  import pb_pkg::*;
#(
  parameter int          FIFO_DEPTH = 64,
  parameter int          VOL_MAX_DB = 64,
  parameter logic [16:0] STEP_Q16   = 17'd58409
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt_sel,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        byte_last,
  input  logic        sof,
  input  logic        ctl_wr,
  input  logic [1:0]  ctl_chan,
  input  logic        ctl_mute_sel,
  input  logic [7:0]  ctl_value,
  input  logic        sample_tick,
  output logic [15:0] dac_left,
  output logic [15:0] dac_right,
  output logic        dac_strobe,
  output logic        ctl_done,
  output logic        ctl_stall
);

  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  pb_frame_t     new_frame, head_frame, scaled;
  logic          frame_valid, pkt_done;
  logic          fifo_empty;
  logic [CW-1:0] fifo_count;
  logic          mute_on;
  pb_seq_e       seq;

  // named events for the checker
  logic playing, take_frame, packet_ready;

  assign playing      = (seq == SEQ_PLAY);
  assign take_frame   = sample_tick && playing && !fifo_empty;
  assign packet_ready = pkt_done && (frame_valid || !fifo_empty);

  pb_unpack u_unpack (
    .clk, .rst_n, .fmt_sel, .byte_valid, .byte_data, .byte_last,
    .frame_valid, .frame(new_frame), .pkt_done
  );

  pb_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .push(frame_valid), .din(new_frame),
    .pop(take_frame), .dout(head_frame),
    .empty(fifo_empty), .count(fifo_count)
  );

  pb_level #(.VOL_MAX_DB(VOL_MAX_DB), .STEP_Q16(STEP_Q16), .CTL_W(8)) u_level (
    .clk, .rst_n, .ctl_wr, .ctl_chan, .ctl_mute_sel, .ctl_value,
    .in_frame(head_frame), .out_frame(scaled), .mute_on, .ctl_done, .ctl_stall
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= SEQ_IDLE;
    end else begin
      case (seq)
        SEQ_IDLE:   if (packet_ready) seq <= SEQ_PRIMED;
        SEQ_PRIMED: if (sof) seq <= SEQ_PLAY;
        SEQ_PLAY:   if (sample_tick && fifo_empty) seq <= SEQ_IDLE;
        default:    seq <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_left   <= '0;
      dac_right  <= '0;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= sample_tick;
      if (sample_tick) begin
        dac_left  <= take_frame ? scaled.l : '0;
        dac_right <= take_frame ? scaled.r : '0;
      end
    end
  end

endmodule

// File: rtl/pb_playback_chk.sv
module pb_playback_chk #(
  parameter int FIFO_DEPTH = 64,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [1:0]    ctl_chan,
  input logic          ctl_mute_sel,
  input logic          ctl_done,
  input logic          ctl_stall,
  input logic          sample_tick,
  input logic          sof,
  input logic [15:0]   dac_left,
  input logic [15:0]   dac_right,
  input logic          dac_strobe,
  input logic          playing,
  input logic          mute_on,
  input logic [CW-1:0] fifo_count
);

  a_r10_master_vol_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_mute_sel && (ctl_chan == 2'd0 || ctl_chan == 2'd3) |=> ctl_done && ctl_stall);

  a_r11_chan_mute_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_mute_sel && ctl_chan != 2'd0 |=> ctl_done && ctl_stall);

  a_r11_master_mute_ok: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_mute_sel && ctl_chan == 2'd0 |=> ctl_done && !ctl_stall);

  a_r12_done_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> !ctl_done && !ctl_stall);

  a_r8_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick && !playing |=> dac_left == 16'd0 && dac_right == 16'd0 && dac_strobe);

  a_r11_muted_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick && mute_on |=> dac_left == 16'd0 && dac_right == 16'd0);

  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |-> $stable(dac_left) && $stable(dac_right));

  a_r7_start_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(playing) |-> $past(sof));

  a_r7_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(FIFO_DEPTH));

endmodule

bind pb_playback_conv pb_playback_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_chan(ctl_chan),
  .ctl_mute_sel(ctl_mute_sel), .ctl_done(ctl_done), .ctl_stall(ctl_stall),
  .sample_tick(sample_tick), .sof(sof), .dac_left(dac_left), .dac_right(dac_right),
  .dac_strobe(dac_strobe), .playing(playing), .mute_on(mute_on), .fifo_count(fifo_count)
);

// File: tb/pb_playback_conv_test.sv
module pb_playback_conv_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_last = 1'b0;
  logic        sof = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [1:0]  ctl_chan = '0;
  logic        ctl_mute_sel = 1'b0;
  logic [7:0]  ctl_value = '0;
  logic        sample_tick = 1'b0;
  logic [15:0] dac_left, dac_right;
  logic        dac_strobe, ctl_done, ctl_stall;

  int checks = 0;
  int fails = 0;

  logic [31:0] exp_q [$];
  logic [7:0]  pkt [0:255];
  int          pkt_len;
  int          m_vol_l = 0, m_vol_r = 0;
  bit          m_mute = 1'b0;

  pb_playback_conv uut (
    .clk, .rst_n, .fmt_sel, .byte_valid, .byte_data, .byte_last, .sof,
    .ctl_wr, .ctl_chan, .ctl_mute_sel, .ctl_value, .sample_tick,
    .dac_left, .dac_right, .dac_strobe, .ctl_done, .ctl_stall
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model gain: repeated 1 dB reduction from unity
  function automatic longint ref_gain(input int db);
    longint g;
    int n;
    if (db >= 64) return 0;
    g = 65536;
    n = db;
    while (n > 0) begin
      g = (g * 58409 + 32768) / 65536;
      n--;
    end
    return g;
  endfunction

  function automatic logic [15:0] ref_level(input logic [15:0] s, input int db, input bit muted);
    longint p;
    if (muted || db >= 64) return 16'h0000;
    p = longint'($signed(s)) * ref_gain(db) + 32768;
    p = p >>> 16;
    return p[15:0];
  endfunction

  // builds random bytes for nfr frames and queues the frames they decode to
  task automatic build_packet(input int fmt, input int nfr);
    logic [7:0] a, b, c, d;
    pkt_len = 0;
    for (int f = 0; f < nfr; f++) begin
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom); d = 8'($urandom);
      case (fmt)
        1: begin pkt[pkt_len] = a; pkt[pkt_len+1] = b; pkt[pkt_len+2] = c; pkt[pkt_len+3] = d;
                 pkt_len += 4; exp_q.push_back({b, a, d, c}); end
        2: begin pkt[pkt_len] = a; pkt[pkt_len+1] = b; pkt_len += 2;
                 exp_q.push_back({b, a, b, a}); end
        3: begin pkt[pkt_len] = a; pkt[pkt_len+1] = b; pkt_len += 2;
                 exp_q.push_back({a, 8'h00, b, 8'h00}); end
        4: begin pkt[pkt_len] = a; pkt_len += 1;
                 exp_q.push_back({a, 8'h00, a, 8'h00}); end
        5: begin pkt[pkt_len] = a; pkt[pkt_len+1] = b; pkt_len += 2;
                 exp_q.push_back({8'(a + 8'd128), 8'h00, 8'(b + 8'd128), 8'h00}); end
        6: begin pkt[pkt_len] = a; pkt_len += 1;
                 exp_q.push_back({8'(a + 8'd128), 8'h00, 8'(a + 8'd128), 8'h00}); end
        default: begin pkt[pkt_len] = a; pkt_len += 1; end
      endcase
    end
  endtask

  task automatic send_packet(input int fmt);
    fmt_sel = 3'(fmt);
    for (int i = 0; i < pkt_len; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = pkt[i];
      byte_last  = (i == pkt_len - 1);
    end
    @(negedge clk);
    byte_valid = 1'b0;
    byte_last  = 1'b0;
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic tick_check(input string tag, input logic [31:0] exp);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    check_eq({tag, " strobe"}, {31'd0, dac_strobe}, 32'd1);
    check_eq(tag, {dac_left, dac_right}, exp);
    @(negedge clk);
  endtask

  task automatic play_out(input string tag);
    logic [31:0] raw;
    pulse_sof();
    while (exp_q.size() > 0) begin
      raw = exp_q.pop_front();
      tick_check(tag, {ref_level(raw[31:16], m_vol_l, m_mute), ref_level(raw[15:0], m_vol_r, m_mute)});
    end
    tick_check("R8 drained", 32'd0);
    tick_check("R8 stays silent", 32'd0);
  endtask

  task automatic ctl(input int chan, input bit is_mute, input int val, input bit exp_stall, input string tag);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_chan = 2'(chan); ctl_mute_sel = is_mute; ctl_value = 8'(val);
    @(negedge clk);
    ctl_wr = 1'b0;
    check_eq({tag, " R12 done"}, {31'd0, ctl_done}, 32'd1);
    check_eq({tag, " stall"}, {31'd0, ctl_stall}, {31'd0, exp_stall});
    @(negedge clk);
    check_eq({tag, " R12 done ends"}, {31'd0, ctl_done}, 32'd0);
    if (!exp_stall) begin
      if (is_mute) m_mute = val[0];
      else if (chan == 1) m_vol_l = (val > 64) ? 64 : val;
      else m_vol_r = (val > 64) ? 64 : val;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tags [1:6];
    tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4"; tags[4] = "R4"; tags[5] = "R5"; tags[6] = "R5";
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check_eq("R1 outputs in reset", {dac_left, dac_right}, 32'd0);
    check_eq("R1 strobe/resp in reset", {29'd0, dac_strobe, ctl_done, ctl_stall}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 after release", {13'd0, dac_strobe, ctl_done, ctl_stall, dac_left}, 32'd0);

    // idle ticks
    tick_check("R7 idle tick", 32'd0);

    // 16-bit stereo, ticks before sof stay silent
    build_packet(1, 6);
    send_packet(1);
    tick_check("R7 primed before sof", 32'd0);
    play_out("R2");

    // each format with directed extreme bytes first
    pkt[0] = 8'h80; pkt[1] = 8'h7F; pkt_len = 2;
    exp_q.push_back({16'h8000, 16'h7F00});
    send_packet(3);
    play_out("R4 extremes");
    pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt_len = 2;
    exp_q.push_back({16'h8000, 16'h7F00});
    send_packet(5);
    play_out("R5 extremes");
    for (int f = 2; f <= 6; f++) begin
      build_packet(f, 5);
      send_packet(f);
      play_out(tags[f]);
    end

    // silent settings
    build_packet(0, 8);
    send_packet(0);
    pulse_sof();
    tick_check("R6 zero bandwidth", 32'd0);
    build_packet(7, 3);
    send_packet(7);
    pulse_sof();
    tick_check("R6 setting 7", 32'd0);
    build_packet(2, 3);
    send_packet(2);
    play_out("R6 no residue");

    // control paths
    ctl(0, 1'b0, 20, 1'b1, "R10 master volume");
    ctl(3, 1'b0, 20, 1'b1, "R10 channel 3 volume");
    build_packet(1, 4);
    send_packet(1);
    play_out("R10 unity kept");
    ctl(1, 1'b0, 7, 1'b0, "R9 left 7dB");
    ctl(2, 1'b0, 90, 1'b0, "R9 right clamp");
    build_packet(1, 6);
    send_packet(1);
    play_out("R9 attenuation");
    ctl(2, 1'b0, 63, 1'b0, "R9 right 63dB");
    pkt[0] = 8'h00; pkt[1] = 8'h80; pkt[2] = 8'hFF; pkt[3] = 8'h7F; pkt_len = 4;
    exp_q.push_back({16'h8000, 16'h7FFF});
    send_packet(1);
    play_out("R9 full scale");
    ctl(1, 1'b1, 1, 1'b1, "R11 left mute");
    build_packet(2, 3);
    send_packet(2);
    play_out("R11 chan mute ignored");
    ctl(0, 1'b1, 1, 1'b0, "R11 master mute");
    build_packet(1, 3);
    send_packet(1);
    play_out("R11 muted");
    ctl(0, 1'b1, 0, 1'b0, "R11 unmute");

    // random rounds
    for (int n = 0; n < 24; n++) begin
      int f;
      f = 1 + int'($urandom % 6);
      ctl(1, 1'b0, int'($urandom % 72), 1'b0, "R9 random left");
      ctl(2, 1'b0, int'($urandom % 72), 1'b0, "R9 random right");
      if ($urandom % 5 == 0) ctl(0, 1'b1, 1, 1'b0, "R11 random mute");
      build_packet(f, 1 + int'($urandom % 16));
      send_packet(f);
      play_out({tags[f], " R9 random"});
      if (m_mute) ctl(0, 1'b1, 0, 1'b0, "R11 random unmute");
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule